// File: doc/BRIEF.md
# Two-Wire Register Target with Dual Output Banks

This block is a slave-only target for a two-wire SMBus/I2C-style bus. It samples the bus with a fast system clock and passes SCL, SDA, the bank-select line and the eight pin inputs through two-flop synchronisers. It detects START and STOP, acknowledges its own 7-bit address, and serves the write-byte, send-byte, read-byte and receive-byte protocols. Every access goes to a small register file that is indexed by a command byte.

The register file holds two banks. Each bank has an output register and two interrupt mask registers, one for rising edges and one for falling edges. A live pin-status location, a fixed identity byte and two action commands complete the file. One command re-samples the address select pins. The other restores all data registers to their power-up values. The level on `sus_n_i` chooses which bank drives the eight open-drain pull-down controls and the two mask outputs, so the host can switch between two prepared configurations with no bus traffic.

A transfer is committed one byte at a time, on the SCL falling edge that ends that byte's acknowledge clock. A byte cut short by START or STOP leaves no trace.

Top module: `smbx_expander`

## Requirements
- R1: After reset, with default parameters, `pin_pull_o` is 0xFF (output registers 0x00), both mask outputs are 0xFF and `sda_oe_o` is 0.
- R2: The block acknowledges only an address byte whose upper seven bits equal the sampled `addr_sel_i`. Any other address is not acknowledged and changes nothing. `sda_oe_o` changes only while SCL is low.
- R3: A write-byte (address with R/W=0, command, data) to command 0x00..0x05 stores the data there: 0x00/0x01/0x02 are the normal output/rise-mask/fall-mask registers, and 0x03/0x04/0x05 are the suspend ones.
- R4: A read-byte (address W, command, repeated START, address R) returns the addressed register on SDA, most significant bit first.
- R5: A receive-byte (address R only) returns the location selected by the last completed command byte. The selection is 0x00 after reset.
- R6: With `sus_n_i` high, registers 0x00/0x01/0x02 drive the outputs. With it low, 0x03/0x04/0x05 drive them.
- R7: Output register bit value 0 sets the matching `pin_pull_o` bit to 1 (pin pulled low). Value 1 releases the pin.
- R8: The data byte of a write-byte to any command above 0x05 (0x06 status, 0x07, 0x08, 0xFE identity) is stored into register 0x00, and the command's own action still happens.
- R9: Command 0x08 resets every data register to its reset value (outputs to 0x00 with default parameters, masks to 0xFF) and leaves the command selection at 0x08. Reads of 0x07, 0x08 and unmapped commands return 0x00.
- R10: Command 0x07 re-samples `addr_sel_i`. After that, only the new address is acknowledged.
- R11: A byte interrupted by START or STOP before it completes is discarded. After a STOP, `sda_oe_o` is 0.
- R12: Reading command 0x06 returns the synchronised `pin_i` levels captured at the end of the read-address acknowledge.
- R13: Reading command 0xFE returns 0x4D.
- R14: A written value reaches the outputs only after the SCL falling edge that ends the data byte's acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sus_n_i | input | 1 | Bank select: 1 normal bank, 0 suspend bank |
| pin_i | input | 8 | Sensed pin levels |
| addr_sel_i | input | 7 | Address select pins, sampled after reset and on command 0x07/0x08 |
| pin_pull_o | output | 8 | Per-pin pull-down enable |
| rise_mask_o | output | 8 | Active rising-edge mask |
| fall_mask_o | output | 8 | Active falling-edge mask |

## Verification
The assertions assume a well-formed master. SDA moves only while SCL is low, except to form START or STOP. The master never starts or stops while the target holds SDA low. Each SCL phase lasts long enough to cover the synchroniser and edge-detect latency. The bench's bit tasks hold each quarter of an SCL period for eight system clocks and change SDA only on quarters where SCL is low. The only deliberate irregularity is a truncated byte, which still ends with a proper START or STOP.

// File: rtl/smbx_pkg.sv
package smbx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;
  localparam int unsigned BANK_SZ = 3;
  localparam int unsigned NUM_REGS = 2 * BANK_SZ;

  localparam logic [BYTE_W-1:0] CMD_PINS     = 8'h06;
  localparam logic [BYTE_W-1:0] CMD_RESAMPLE = 8'h07;
  localparam logic [BYTE_W-1:0] CMD_SOFTRST  = 8'h08;
  localparam logic [BYTE_W-1:0] CMD_IDENT    = 8'hFE;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_ACK, ST_TX, ST_MACK, ST_WAIT
  } bus_state_e;

  typedef enum logic [1:0] {
    ACK_ADDR, ACK_CMD, ACK_DATA
  } ack_kind_e;
endpackage

// File: rtl/smbx_sync.sv
module smbx_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/smbx_cond.sv
module smbx_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s && !scl_q;
    scl_fall  = !scl_s && scl_q;
    start_evt = scl_s && scl_q && sda_q && !sda_s;
    stop_evt  = scl_s && scl_q && !sda_q && sda_s;
  end
endmodule

// File: rtl/smbx_bus.sv
module smbx_bus
  import smbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              cmd_stb,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int unsigned CNT_W = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  bus_state_e       st_q, st_d;
  ack_kind_e        kind_q, kind_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic             rw_q, rw_d;

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    cmd_stb = 1'b0;
    wr_stb  = 1'b0;
    if (start_evt) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
    end else if (stop_evt) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (scl_rise && (cnt_q < LAST_BIT)) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == LAST_BIT)) begin
            cnt_d = '0;
            if (st_q == ST_ADDR) begin
              if (sh_q[BYTE_W-1:1] == dev_addr) begin
                st_d   = ST_ACK;
                kind_d = ACK_ADDR;
                rw_d   = sh_q[0];
              end else begin
                st_d = ST_WAIT;
              end
            end else if (st_q == ST_CMD) begin
              st_d   = ST_ACK;
              kind_d = ACK_CMD;
            end else begin
              st_d   = ST_ACK;
              kind_d = ACK_DATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            case (kind_q)
              ACK_ADDR: begin
                if (rw_q) begin
                  st_d = ST_TX;
                  sh_d = rd_data;
                end else begin
                  st_d = ST_CMD;
                end
              end
              ACK_CMD: begin
                cmd_stb = 1'b1;
                st_d    = ST_WDATA;
              end
              default: begin
                wr_stb = 1'b1;
                st_d   = ST_WAIT;
              end
            endcase
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            sh_d = {sh_q[BYTE_W-2:0], 1'b1};
            if (cnt_q == LAST_BIT - 1'b1) begin
              st_d  = ST_MACK;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_fall) st_d = ST_WAIT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= ACK_ADDR;
      cnt_q  <= '0;
      sh_q   <= '0;
      rw_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      rw_q   <= rw_d;
    end
  end

  assign sda_oe  = (st_q == ST_ACK) || ((st_q == ST_TX) && !sh_q[BYTE_W-1]);
  assign rx_byte = sh_q;
endmodule

// File: rtl/smbx_regs.sv
module smbx_regs
  import smbx_pkg::*;
#(
  parameter bit               OUT_RST_HIGH = 1'b0,
  parameter logic [BYTE_W-1:0] ID_CODE     = 8'h4D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              sus_n_s,
  input  logic [BYTE_W-1:0] pin_s,
  input  logic [ADDR_W-1:0] addr_sel_i,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] pin_pull,
  output logic [BYTE_W-1:0] rise_mask,
  output logic [BYTE_W-1:0] fall_mask
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  localparam logic [BYTE_W-1:0] OUT_RST = OUT_RST_HIGH ? '1 : '0;
  localparam logic [BYTE_W-1:0] MAP_TOP = BYTE_W'(NUM_REGS);

  logic [BYTE_W-1:0] regs_q [NUM_REGS];
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              samp_q, samp_d;
  logic              soft_rst;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  base;
  logic [BYTE_W-1:0] out_sel;

  always_comb begin
    soft_rst = cmd_stb && (rx_byte == CMD_SOFTRST);
    wr_idx   = (ptr_q < MAP_TOP) ? ptr_q[IDX_W-1:0] : '0;
  end

  for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_reg
    localparam logic [BYTE_W-1:0] RV = ((g % int'(BANK_SZ)) == 0) ? OUT_RST : '1;
    logic [BYTE_W-1:0] reg_d;
    always_comb begin
      reg_d = regs_q[g];
      if (soft_rst) reg_d = RV;
      if (wr_stb && (wr_idx == IDX_W'(g))) reg_d = rx_byte;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= RV;
      else        regs_q[g] <= reg_d;
    end
  end

  always_comb begin
    ptr_d  = ptr_q;
    samp_d = samp_q;
    addr_d = addr_q;
    if (samp_q) begin
      addr_d = addr_sel_i;
      samp_d = 1'b0;
    end
    if (cmd_stb) begin
      ptr_d = rx_byte;
      if ((rx_byte == CMD_RESAMPLE) || (rx_byte == CMD_SOFTRST)) samp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      samp_q <= 1'b1;
      addr_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      samp_q <= samp_d;
      addr_q <= addr_d;
    end
  end

  always_comb begin
    if (ptr_q < MAP_TOP)           rd_data = regs_q[ptr_q[IDX_W-1:0]];
    else if (ptr_q == CMD_PINS)    rd_data = pin_s;
    else if (ptr_q == CMD_IDENT)   rd_data = ID_CODE;
    else                           rd_data = '0;
  end

  always_comb begin
    base      = sus_n_s ? '0 : IDX_W'(BANK_SZ);
    out_sel   = regs_q[base];
    rise_mask = regs_q[base + IDX_W'(1)];
    fall_mask = regs_q[base + IDX_W'(2)];
    pin_pull  = ~out_sel;
  end

  assign dev_addr = addr_q;
endmodule

// File: rtl/smbx_expander.sv
module smbx_expander
  import smbx_pkg::*;
#(
  parameter bit               OUT_RST_HIGH = 1'b0,
  parameter logic [BYTE_W-1:0] ID_CODE     = 8'h4D,
  parameter int unsigned      SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              sus_n_i,
  input  logic [BYTE_W-1:0] pin_i,
  input  logic [ADDR_W-1:0] addr_sel_i,
  output logic [BYTE_W-1:0] pin_pull_o,
  output logic [BYTE_W-1:0] rise_mask_o,
  output logic [BYTE_W-1:0] fall_mask_o
);
  logic [2:0]        ctl_s;
  logic              scl_s, sda_s, sus_n_s;
  logic [BYTE_W-1:0] pin_s;
  logic              scl_rise, scl_fall, start_evt, stop_evt;
  logic [ADDR_W-1:0] dev_addr;
  logic [BYTE_W-1:0] rd_data, rx_byte;
  logic              cmd_stb, wr_stb;

  smbx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({sus_n_i, scl_i, sda_i}), .q(ctl_s)
  );
  assign {sus_n_s, scl_s, sda_s} = ctl_s;

  smbx_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s)
  );

  smbx_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smbx_bus u_bus (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .dev_addr(dev_addr), .rd_data(rd_data), .sda_oe(sda_oe_o),
    .cmd_stb(cmd_stb), .wr_stb(wr_stb), .rx_byte(rx_byte)
  );

  smbx_regs #(.OUT_RST_HIGH(OUT_RST_HIGH), .ID_CODE(ID_CODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .wr_stb(wr_stb),
    .rx_byte(rx_byte), .sus_n_s(sus_n_s), .pin_s(pin_s),
    .addr_sel_i(addr_sel_i), .dev_addr(dev_addr), .rd_data(rd_data),
    .pin_pull(pin_pull_o), .rise_mask(rise_mask_o), .fall_mask(fall_mask_o)
  );
endmodule

// File: rtl/smbx_chk.sv
module smbx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sus_n_s,
  input logic       sda_oe,
  input logic       stop_evt,
  input logic       cmd_stb,
  input logic       wr_stb,
  input logic [7:0] rx_byte,
  input logic [7:0] pin_pull,
  input logic [7:0] rise_mask,
  input logic [7:0] fall_mask
);
  // R2
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && (rx_byte == 8'h08)) |=> ((rise_mask == 8'hFF) && (fall_mask == 8'hFF)));

  // R14
  update_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb || cmd_stb) |=> (!$stable(sus_n_s) || $stable(pin_pull)));

  // R6
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb || cmd_stb) |=> (!$stable(sus_n_s) || ($stable(rise_mask) && $stable(fall_mask))));
endmodule

bind smbx_expander smbx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sus_n_s(sus_n_s),
  .sda_oe(sda_oe_o), .stop_evt(stop_evt), .cmd_stb(cmd_stb),
  .wr_stb(wr_stb), .rx_byte(rx_byte), .pin_pull(pin_pull_o),
  .rise_mask(rise_mask_o), .fall_mask(fall_mask_o)
);

// File: tb/tb_smbx_expander.sv
module tb_smbx_expander;
  localparam logic [6:0] DEV_A = 7'h2A;
  localparam logic [6:0] DEV_B = 7'h31;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sus_n = 1'b1;
  logic [7:0] pins = 8'h00;
  logic [6:0] addr_sel = DEV_A;
  logic       sda_oe;
  logic       sda_bus;
  logic [7:0] pin_pull, rise_mask, fall_mask;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  smbx_expander dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .sus_n_i(sus_n), .pin_i(pins), .addr_sel_i(addr_sel),
    .pin_pull_o(pin_pull), .rise_mask_o(rise_mask), .fall_mask_o(fall_mask)
  );

  task automatic q(); repeat (8) @(negedge clk); endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nak);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; q(); scl = 1'b1; q(); nak = sda_bus; q(); scl = 1'b0; q();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; q(); scl = 1'b1; q(); b = {b[6:0], sda_bus}; q(); scl = 1'b0; q();
    end
    send_bit(nack);
  endtask

  task automatic wr_xfer(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d, output logic nak);
    logic k0, k1, k2;
    bus_start(); send_byte({a, 1'b0}, k0); send_byte(c, k1); send_byte(d, k2); bus_stop();
    nak = k0 | k1 | k2;
  endtask

  task automatic cmd_xfer(input logic [6:0] a, input logic [7:0] c, output logic nak);
    logic k0, k1;
    bus_start(); send_byte({a, 1'b0}, k0); send_byte(c, k1); bus_stop();
    nak = k0 | k1;
  endtask

  task automatic rd_xfer(input logic [6:0] a, input logic [7:0] c, output logic [7:0] d);
    logic k0, k1, k2;
    bus_start(); send_byte({a, 1'b0}, k0); send_byte(c, k1);
    bus_start(); send_byte({a, 1'b1}, k2); recv_byte(1'b1, d); bus_stop();
  endtask

  task automatic rcv_xfer(input logic [6:0] a, output logic [7:0] d);
    logic k0;
    bus_start(); send_byte({a, 1'b1}, k0); recv_byte(1'b1, d); bus_stop();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 pin_pull after reset", pin_pull, 8'hFF);
    check("R1 rise mask after reset", rise_mask, 8'hFF);
    check("R1 fall mask after reset", fall_mask, 8'hFF);
    check("R1 sda released after reset", sda_oe, 1'b0);
    rcv_xfer(DEV_A, d);
    check("R5 receive-byte after reset reads 0x00", d, 8'h00);
  endtask

  task automatic t_addr();
    logic nak;
    wr_xfer(7'h55, 8'h00, 8'h00, nak);
    check("R2 foreign address not acknowledged", nak, 1'b1);
    check("R2 foreign write ignored", pin_pull, 8'hFF);
    wr_xfer(DEV_A, 8'h00, 8'hFF, nak);
    check("R2 own address acknowledged", nak, 1'b0);
  endtask

  task automatic t_write_read();
    logic nak;
    logic [7:0] d;
    wr_xfer(DEV_A, 8'h00, 8'hA5, nak);
    check("R7 output polarity", pin_pull, 8'h5A);
    wr_xfer(DEV_A, 8'h01, 8'h3C, nak);
    check("R3 normal rise mask", rise_mask, 8'h3C);
    wr_xfer(DEV_A, 8'h02, 8'hC3, nak);
    check("R3 normal fall mask", fall_mask, 8'hC3);
    rd_xfer(DEV_A, 8'h00, d);
    check("R4 read-byte of 0x00", d, 8'hA5);
    rd_xfer(DEV_A, 8'h01, d);
    rcv_xfer(DEV_A, d);
    check("R5 receive-byte follows last command", d, 8'h3C);
  endtask

  task automatic t_bank();
    logic nak;
    logic [7:0] d;
    wr_xfer(DEV_A, 8'h03, 8'h0F, nak);
    wr_xfer(DEV_A, 8'h04, 8'h11, nak);
    wr_xfer(DEV_A, 8'h05, 8'h22, nak);
    check("R6 normal bank still drives", pin_pull, 8'h5A);
    rd_xfer(DEV_A, 8'h05, d);
    check("R3 suspend fall mask stored", d, 8'h22);
    sus_n = 1'b0; q();
    check("R6 suspend outputs", pin_pull, 8'hF0);
    check("R6 suspend rise mask", rise_mask, 8'h11);
    check("R6 suspend fall mask", fall_mask, 8'h22);
    sus_n = 1'b1; q();
    check("R6 back to normal bank", rise_mask, 8'h3C);
  endtask

  task automatic t_status_id();
    logic nak;
    logic [7:0] d;
    pins = 8'h96; q();
    rd_xfer(DEV_A, 8'h06, d);
    check("R12 pin status read", d, 8'h96);
    rd_xfer(DEV_A, 8'hFE, d);
    check("R13 identity byte", d, 8'h4D);
    wr_xfer(DEV_A, 8'h06, 8'h77, nak);
    check("R8 write to status lands in 0x00", pin_pull, 8'h88);
    rd_xfer(DEV_A, 8'h06, d);
    check("R8 status location unchanged", d, 8'h96);
    wr_xfer(DEV_A, 8'hFE, 8'h31, nak);
    check("R8 write to identity lands in 0x00", pin_pull, 8'hCE);
  endtask

  task automatic t_timing();
    logic nak;
    bus_start(); send_byte({DEV_A, 1'b0}, nak); send_byte(8'h00, nak);
    for (int i = 7; i >= 0; i--) send_bit(i == 7 || i == 0);
    sda_m = 1'b1; q(); scl = 1'b1; q();
    check("R14 no update during ack clock", pin_pull, 8'hCE);
    q(); scl = 1'b0; q();
    check("R14 update after ack clock falls", pin_pull, 8'h7E);
    bus_stop();
  endtask

  task automatic t_trunc();
    logic nak;
    logic [7:0] d;
    wr_xfer(DEV_A, 8'h00, 8'h3C, nak);
    bus_start(); send_byte({DEV_A, 1'b0}, nak); send_byte(8'h00, nak);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    check("R11 byte cut by STOP discarded", pin_pull, 8'hC3);
    check("R11 SDA released after STOP", sda_oe, 1'b0);
    bus_start(); send_byte({DEV_A, 1'b0}, nak); send_byte(8'h01, nak);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    bus_start(); send_byte({DEV_A, 1'b1}, nak); recv_byte(1'b1, d); bus_stop();
    check("R11 byte cut by START discarded", rise_mask, 8'h3C);
    check("R5 completed command byte kept", d, 8'h3C);
  endtask

  task automatic t_spor();
    logic nak;
    logic [7:0] d;
    wr_xfer(DEV_A, 8'h04, 8'h00, nak);
    wr_xfer(DEV_A, 8'h08, 8'h5A, nak);
    check("R8 data after soft reset lands in 0x00", pin_pull, 8'hA5);
    check("R9 rise mask restored", rise_mask, 8'hFF);
    check("R9 fall mask restored", fall_mask, 8'hFF);
    rcv_xfer(DEV_A, d);
    check("R9 selection stays at 0x08", d, 8'h00);
    sus_n = 1'b0; q();
    check("R9 suspend outputs restored", pin_pull, 8'hFF);
    check("R9 suspend rise mask restored", rise_mask, 8'hFF);
    sus_n = 1'b1; q();
    cmd_xfer(DEV_A, 8'h08, nak);
    check("R9 send-byte soft reset", pin_pull, 8'hFF);
  endtask

  task automatic t_rap();
    logic nak;
    addr_sel = DEV_B;
    cmd_xfer(DEV_A, 8'h07, nak);
    check("R10 resample command acknowledged", nak, 1'b0);
    cmd_xfer(DEV_A, 8'h00, nak);
    check("R10 old address dropped", nak, 1'b1);
    wr_xfer(DEV_B, 8'h00, 8'h0F, nak);
    check("R10 new address acknowledged", nak, 1'b0);
    check("R10 write at new address", pin_pull, 8'hF0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_addr();
    t_write_read();
    t_bank();
    t_status_id();
    t_timing();
    t_trunc();
    t_spor();
    t_rap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule